// File: doc/BRIEF.md
# Receive FIFO Message-Object Allocator

This block decides which message object receives an accepted incoming frame when a run of consecutive message objects is chained as a single receive FIFO. A store request names the group as a first and a last object index. The block searches that span and picks the lowest-numbered object that is free to take a frame. It then raises a write strobe with the chosen index and marks that object as holding new data.

An object that holds unread data is locked until the processor clears its new-data flag through a dedicated clear port. The one exception is the object flagged as end-of-buffer, which closes the group. It is never locked. When every object ahead of it is occupied, it takes each new frame, and a one-cycle pulse reports that unread data was overwritten. Identifier filtering, frame payload storage and the bus protocol engine are handled elsewhere.

Top module: `rxf_alloc`

## Requirements
- R1: While reset is asserted and right after it, every new-data flag is 0, and both the write strobe and the overwrite pulse are 0.
- R2: A store request sampled at a clock edge gives `wr_stb`=1 with the chosen index on `wr_idx` in the following cycle. Indices are 0-based: object k is index k-1, and the lower index has the higher priority.
- R3: Storing a frame into an object sets that object's new-data flag on `newdat` in the cycle the strobe appears.
- R4: An object whose new-data flag is 1 and whose end-of-buffer flag is 0 is skipped. The search moves on to the next higher index in the span.
- R5: When every lower object in the span is locked, the end-of-buffer object is chosen for each further frame.
- R6: `ovr_pulse` is 1 for the cycle of a strobe that writes an object whose new-data flag was already 1. In every other cycle it is 0.
- R7: A clear request removes the addressed new-data flag at the next edge. If a store and a clear address the same object in the same cycle, the flag ends up 1. The selection for a store always uses the flags as they stood before that edge.
- R8: Only indices from `st_first` to `st_last` inclusive are considered. A free object outside the span is never chosen.
- R9: If the span holds no eligible object, no strobe is raised and the flags are unchanged. This covers a locked span without an end-of-buffer object and a span where first > last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_vld | input | 1 | Store request for an accepted frame |
| st_first | input | IDX_W | First object index of the matched group |
| st_last | input | IDX_W | Last object index of the matched group |
| eob | input | NUM_OBJ | Per-object end-of-buffer flags |
| clr_vld | input | 1 | Processor request to clear a new-data flag |
| clr_idx | input | IDX_W | Object index to clear |
| wr_stb | output | 1 | Write strobe, one cycle per stored frame |
| wr_idx | output | IDX_W | Chosen object index |
| newdat | output | NUM_OBJ | New-data flags of all objects |
| ovr_pulse | output | 1 | Unread data in the chosen object was overwritten |

## Verification
The bench uses the default of 32 objects, so the index width is 5 and the search spans the full range up to index 31. The end-of-buffer flags are set at indices 3, 7 and 15. This gives two short terminated groups and one long one. Indices 20 to 22 form a span with no terminator, which makes the no-slot case reachable. Within that setup the bench drives repeated overwrites, clears that race a store to the same object, inverted spans, and searches that must skip locked objects.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned RXF_DEF_OBJS = 32;

  function automatic logic span_hit(input int unsigned idx,
                                    input int unsigned lo,
                                    input int unsigned hi);
    return (idx >= lo) && (idx <= hi);
  endfunction
endpackage

// File: rtl/rxf_elig_mask.sv
module rxf_elig_mask #(
  parameter int unsigned NUM_OBJ = 32,
  parameter int unsigned IDX_W   = $clog2(NUM_OBJ)
) (
  input  logic [IDX_W-1:0]   first_i,
  input  logic [IDX_W-1:0]   last_i,
  input  logic [NUM_OBJ-1:0] newdat_i,
  input  logic [NUM_OBJ-1:0] eob_i,
  output logic [NUM_OBJ-1:0] elig_o
);
  import rxf_pkg::*;

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    logic in_span;
    logic locked;
    assign in_span   = span_hit(g, int'(first_i), int'(last_i));
    assign locked    = newdat_i[g] & ~eob_i[g];
    assign elig_o[g] = in_span & ~locked;
  end
endmodule

// File: rtl/rxf_pick_low.sv
module rxf_pick_low #(
  parameter int unsigned NUM_OBJ = 32,
  parameter int unsigned IDX_W   = $clog2(NUM_OBJ)
) (
  input  logic [NUM_OBJ-1:0] req_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_OBJ - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rxf_flag_bank.sv
module rxf_flag_bank #(
  parameter int unsigned NUM_OBJ = 32,
  parameter int unsigned IDX_W   = $clog2(NUM_OBJ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en_i,
  input  logic [IDX_W-1:0]   set_idx_i,
  input  logic               clr_en_i,
  input  logic [IDX_W-1:0]   clr_idx_i,
  output logic [NUM_OBJ-1:0] flags_o
);
  logic [NUM_OBJ-1:0] flags_q;
  logic [NUM_OBJ-1:0] flags_d;

  always_comb begin
    flags_d = flags_q;
    if (clr_en_i) flags_d[clr_idx_i] = 1'b0;
    if (set_en_i) flags_d[set_idx_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (set_en_i || clr_en_i) begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/rxf_alloc.sv
module rxf_alloc #(
  parameter int unsigned NUM_OBJ = rxf_pkg::RXF_DEF_OBJS,
  parameter int unsigned IDX_W   = $clog2(NUM_OBJ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               st_vld,
  input  logic [IDX_W-1:0]   st_first,
  input  logic [IDX_W-1:0]   st_last,
  input  logic [NUM_OBJ-1:0] eob,
  input  logic               clr_vld,
  input  logic [IDX_W-1:0]   clr_idx,
  output logic               wr_stb,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [NUM_OBJ-1:0] newdat,
  output logic               ovr_pulse
);
  logic [NUM_OBJ-1:0] elig;
  logic               pick_found;
  logic [IDX_W-1:0]   pick_idx;
  logic               do_store;

  logic               stb_d, stb_q;
  logic [IDX_W-1:0]   idx_d, idx_q;
  logic               ovr_d, ovr_q;

  rxf_elig_mask #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_mask (
    .first_i  (st_first),
    .last_i   (st_last),
    .newdat_i (newdat),
    .eob_i    (eob),
    .elig_o   (elig)
  );

  rxf_pick_low #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_pick (
    .req_i   (elig),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  assign do_store = st_vld & pick_found;

  rxf_flag_bank #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en_i  (do_store),
    .set_idx_i (pick_idx),
    .clr_en_i  (clr_vld),
    .clr_idx_i (clr_idx),
    .flags_o   (newdat)
  );

  always_comb begin
    stb_d = do_store;
    idx_d = idx_q;
    ovr_d = 1'b0;
    if (do_store) begin
      idx_d = pick_idx;
      ovr_d = newdat[pick_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      idx_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      stb_q <= stb_d;
      ovr_q <= ovr_d;
      if (do_store) idx_q <= idx_d;
    end
  end

  assign wr_stb    = stb_q;
  assign wr_idx    = idx_q;
  assign ovr_pulse = ovr_q;
endmodule

// File: rtl/rxf_alloc_chk.sv
module rxf_alloc_chk #(
  parameter int unsigned NUM_OBJ = 32,
  parameter int unsigned IDX_W   = $clog2(NUM_OBJ)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               st_vld,
  input logic [IDX_W-1:0]   st_first,
  input logic [IDX_W-1:0]   st_last,
  input logic [NUM_OBJ-1:0] eob,
  input logic               clr_vld,
  input logic [IDX_W-1:0]   clr_idx,
  input logic               wr_stb,
  input logic [IDX_W-1:0]   wr_idx,
  input logic [NUM_OBJ-1:0] newdat,
  input logic               ovr_pulse
);
  logic [NUM_OBJ-1:0] nd_prev;
  logic [NUM_OBJ-1:0] eob_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nd_prev  <= '0;
      eob_prev <= '0;
    end else begin
      nd_prev  <= newdat;
      eob_prev <= eob;
    end
  end

  p_stb_needs_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(st_vld));

  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> newdat[wr_idx]);

  p_locked_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !eob_prev[wr_idx]) |-> !nd_prev[wr_idx]);

  p_ovr_on_eob_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_pulse |-> (wr_stb && eob_prev[wr_idx] && nd_prev[wr_idx]));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_vld) && !(wr_stb && wr_idx == $past(clr_idx)))
      |-> !newdat[$past(clr_idx)]);

  p_in_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_idx >= $past(st_first) && wr_idx <= $past(st_last)));
endmodule

bind rxf_alloc rxf_alloc_chk #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_vld    (st_vld),
  .st_first  (st_first),
  .st_last   (st_last),
  .eob       (eob),
  .clr_vld   (clr_vld),
  .clr_idx   (clr_idx),
  .wr_stb    (wr_stb),
  .wr_idx    (wr_idx),
  .newdat    (newdat),
  .ovr_pulse (ovr_pulse)
);

// File: tb/rxf_alloc_tb.sv
module rxf_alloc_tb;
  localparam int unsigned NUM_OBJ = 32;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned NVEC    = 22;

  // row: st(1) first(5) last(5) clr(1) cidx(5) estb(1) eidx(5) eovr(1) req(4)
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b1,5'd0, 5'd3, 1'b0,5'd0,1'b1,5'd0, 1'b0,4'd2}, // R2 first slot
    {1'b1,5'd0, 5'd3, 1'b0,5'd0,1'b1,5'd1, 1'b0,4'd2}, // R2
    {1'b1,5'd0, 5'd3, 1'b0,5'd0,1'b1,5'd2, 1'b0,4'd4}, // R4 skip 0,1
    {1'b1,5'd0, 5'd3, 1'b0,5'd0,1'b1,5'd3, 1'b0,4'd5}, // R5 eob, was free
    {1'b1,5'd0, 5'd3, 1'b0,5'd0,1'b1,5'd3, 1'b1,4'd6}, // R6 overwrite
    {1'b1,5'd0, 5'd3, 1'b0,5'd0,1'b1,5'd3, 1'b1,4'd6}, // R6 again
    {1'b0,5'd0, 5'd0, 1'b1,5'd1,1'b0,5'd0, 1'b0,4'd7}, // R7 clear idx1
    {1'b1,5'd0, 5'd3, 1'b0,5'd0,1'b1,5'd1, 1'b0,4'd7}, // R7 freed slot reused
    {1'b1,5'd0, 5'd3, 1'b0,5'd0,1'b1,5'd3, 1'b1,4'd5}, // R5
    {1'b1,5'd4, 5'd7, 1'b0,5'd0,1'b1,5'd4, 1'b0,4'd8}, // R8 second group
    {1'b1,5'd4, 5'd7, 1'b1,5'd5,1'b1,5'd5, 1'b0,4'd7}, // R7 store+clear same obj
    {1'b1,5'd4, 5'd7, 1'b0,5'd0,1'b1,5'd6, 1'b0,4'd7}, // R7 idx5 stayed set
    {1'b1,5'd0, 5'd3, 1'b1,5'd0,1'b1,5'd3, 1'b1,4'd7}, // R7 old flags used
    {1'b1,5'd0, 5'd3, 1'b0,5'd0,1'b1,5'd0, 1'b0,4'd7}, // R7 clear took effect
    {1'b1,5'd8, 5'd15,1'b0,5'd0,1'b1,5'd8, 1'b0,4'd8}, // R8
    {1'b1,5'd8, 5'd8, 1'b0,5'd0,1'b0,5'd0, 1'b0,4'd9}, // R9 locked, no eob
    {1'b1,5'd5, 5'd2, 1'b0,5'd0,1'b0,5'd0, 1'b0,4'd9}, // R9 inverted span
    {1'b1,5'd20,5'd22,1'b0,5'd0,1'b1,5'd20,1'b0,4'd8}, // R8 free lower ignored
    {1'b1,5'd20,5'd22,1'b0,5'd0,1'b1,5'd21,1'b0,4'd4}, // R4
    {1'b1,5'd20,5'd22,1'b0,5'd0,1'b1,5'd22,1'b0,4'd4}, // R4
    {1'b1,5'd20,5'd22,1'b0,5'd0,1'b0,5'd0, 1'b0,4'd9}, // R9 full, unterminated
    {1'b1,5'd21,5'd31,1'b0,5'd0,1'b1,5'd23,1'b0,4'd4}  // R4 skips 21,22
  };

  logic               clk;
  logic               rst_n;
  logic               st_vld;
  logic [IDX_W-1:0]   st_first, st_last;
  logic [NUM_OBJ-1:0] eob;
  logic               clr_vld;
  logic [IDX_W-1:0]   clr_idx;
  logic               wr_stb;
  logic [IDX_W-1:0]   wr_idx;
  logic [NUM_OBJ-1:0] newdat;
  logic               ovr_pulse;

  int checks;
  int errors;
  logic [NUM_OBJ-1:0] exp_nd;

  rxf_alloc #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .st_vld(st_vld), .st_first(st_first),
    .st_last(st_last), .eob(eob), .clr_vld(clr_vld), .clr_idx(clr_idx),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .newdat(newdat), .ovr_pulse(ovr_pulse)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    checks  = 0;
    errors  = 0;
    rst_n   = 1'b0;
    st_vld  = 1'b0;
    st_first = '0;
    st_last  = '0;
    clr_vld = 1'b0;
    clr_idx = '0;
    eob     = '0;
    eob[3]  = 1'b1;
    eob[7]  = 1'b1;
    eob[15] = 1'b1;
    exp_nd  = '0;
    repeat (3) @(negedge clk);
    chk("R1 newdat", 64'(newdat), 64'd0);
    chk("R1 wr_stb", 64'(wr_stb), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ovr", 64'(ovr_pulse), 64'd0);

    for (int v = 0; v < int'(NVEC); v++) begin
      logic [27:0] r;
      string tag;
      r = VEC[v];
      tag = $sformatf("R%0d row%0d", r[3:0], v);
      st_vld   = r[27];
      st_first = r[26:22];
      st_last  = r[21:17];
      clr_vld  = r[16];
      clr_idx  = r[15:11];
      if (r[16]) exp_nd[r[15:11]] = 1'b0;
      if (r[10]) exp_nd[r[9:5]]   = 1'b1;
      @(negedge clk);
      st_vld  = 1'b0;
      clr_vld = 1'b0;
      chk({tag, " stb"}, 64'(wr_stb), 64'(r[10]));
      if (r[10]) chk({tag, " idx"}, 64'(wr_idx), 64'(r[9:5]));
      chk({tag, " ovr"}, 64'(ovr_pulse), 64'(r[4]));
      chk({tag, " R3 newdat"}, 64'(newdat), 64'(exp_nd));
    end

    // R6: pulse lasts one cycle only
    @(negedge clk);
    chk("R6 pulse cleared", 64'(ovr_pulse), 64'd0);
    chk("R2 idle stb", 64'(wr_stb), 64'd0);

    // R1: reset mid-run clears all flags
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-reset newdat", 64'(newdat), 64'd0);
    chk("R1 mid-reset stb", 64'(wr_stb), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: after reset a store to the third group starts at its base again
    st_vld = 1'b1; st_first = 5'd8; st_last = 5'd15;
    @(negedge clk);
    st_vld = 1'b0;
    chk("R2 post-reset idx", 64'(wr_idx), 64'd8);
    chk("R6 post-reset ovr", 64'(ovr_pulse), 64'd0);

    finish_run();
  end
endmodule